// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes incoming frames from a byte stream and places each one into memory through a ring of receive descriptors. Software builds the ring in memory and programs its base address and length. It then hands descriptors to the engine by moving a release index. For each frame the engine reads the buffer address from the descriptor at its own DMA index and writes the frame bytes into that buffer in order. It then marks the descriptor complete with the frame length, and steps its index on around the ring.

The engine never writes into the descriptor that software last released. When its DMA index has caught up with the release index, the ring is full and incoming frames are discarded. Frames that begin while receive is disabled are also discarded whole. A frame larger than one buffer is cut off at the buffer size, is not reported, and leaves the descriptor for the next frame. Memory is reached through a single request/grant port whose read data returns on a later cycle.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the DMA index reads 0, the config register reads 0 (receive off, not busy), `s_ready` is low and no memory request is made.
- R2: Register word addresses: 0 ring base, 1 descriptor count, 2 release index, 3 DMA index (read only), 4 config (bit 2 enable, read/write; bit 3 busy, read only), 5 index reset (write only). Written values read back.
- R3: Each descriptor is 16 bytes at base + 16*index. The buffer address is read from the descriptor word at offset 0, and `s_ready` stays low while that read is outstanding.
- R4: Frame byte n is written to buffer address + n with a single-byte lane enable, in arrival order.
- R5: After the last byte of a stored frame, the engine writes the descriptor word at offset 4 with bit 31 (done) set, bit 30 (last segment) set, the byte count in bits 29:16 and zero in bits 15:0.
- R6: After each completion the DMA index advances by one and wraps from count-1 to 0.
- R7: While the DMA index equals the release index, an arriving frame is consumed with no memory write, and the index is unchanged.
- R8: Writing a different release index frees the ring, and the next frame is stored and reported.
- R9: A buffer holds 2048 bytes. A frame of exactly 2048 bytes is reported with length 2048. A longer frame has only its first 2048 bytes written, gets no completion write, and leaves the DMA index unchanged.
- R10: A frame that starts while enable is 0 is consumed with no memory access and no index change.
- R11: Writing register 5 with bit 16 set forces the DMA index to 0. A write with bit 16 clear has no effect on the index.
- R12: Config bit 3 reads 1 while a frame is in progress and 0 once it has been completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final byte of frame |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest state to reach from the ports is the ring-full condition, where the DMA index has caught up with the release index. The bench reaches it by first running enough frames to wrap the ring, releasing each descriptor behind it. It then writes the release index equal to the DMA index and shows that a frame vanishes without any memory traffic. The truncation path needs a frame one byte over the buffer size, so the bench counts buffer writes rather than mirroring 2048 bytes of memory. Grant stalls on alternate cycles are mixed into the vector table so that byte acceptance is exercised under backpressure.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam logic [2:0] REG_BASE   = 3'd0;
  localparam logic [2:0] REG_COUNT  = 3'd1;
  localparam logic [2:0] REG_REL    = 3'd2;
  localparam logic [2:0] REG_IDX    = 3'd3;
  localparam logic [2:0] REG_CFG    = 3'd4;
  localparam logic [2:0] REG_IDXRST = 3'd5;

  localparam int CFG_EN_BIT   = 2;
  localparam int CFG_BUSY_BIT = 3;
  localparam int IDXRST_BIT   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DROP, ST_FETCH, ST_WAIT, ST_DATA, ST_DONE
  } rx_state_e;

  function automatic logic [31:0] desc_word_addr(input logic [31:0] base,
                                                 input logic [31:0] idx,
                                                 input logic [1:0]  word);
    return base + (idx << 4) + {28'h0, word, 2'b00};
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] count);
    return (idx + 32'd1 >= count) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic logic [31:0] done_word(input logic [31:0] len);
    return {1'b1, 1'b1, len[13:0], 16'h0000};
  endfunction

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic [IDX_W-1:0] dma_idx,
  output logic [31:0]      ring_base,
  output logic [IDX_W:0]   ring_count,
  output logic [IDX_W-1:0] rel_idx,
  output logic             rx_en,
  output logic             idx_clr
);
  localparam int CW = IDX_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_base  <= '0;
      ring_count <= '0;
      rel_idx    <= '0;
      rx_en      <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        REG_BASE:  ring_base  <= reg_wdata;
        REG_COUNT: ring_count <= reg_wdata[CW-1:0];
        REG_REL:   rel_idx    <= reg_wdata[IDX_W-1:0];
        REG_CFG:   rx_en      <= reg_wdata[CFG_EN_BIT];
        default: ;
      endcase
    end
  end

  assign idx_clr = reg_wr && (reg_addr == REG_IDXRST) && reg_wdata[IDXRST_BIT];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_BASE:  reg_rdata = ring_base;
      REG_COUNT: reg_rdata = 32'(ring_count);
      REG_REL:   reg_rdata = 32'(rel_idx);
      REG_IDX:   reg_rdata = 32'(dma_idx);
      REG_CFG: begin
        reg_rdata[CFG_EN_BIT]   = rx_en;
        reg_rdata[CFG_BUSY_BIT] = busy;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring
  import rxdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [IDX_W:0]   ring_count,
  input  logic [IDX_W-1:0] rel_idx,
  output logic [IDX_W-1:0] dma_idx,
  output logic             full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dma_idx <= '0;
    else if (clr) dma_idx <= '0;
    else if (adv) dma_idx <= IDX_W'(ring_next(32'(dma_idx), 32'(ring_count)));
  end

  assign full = (dma_idx == rel_idx);

  AST_IDX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dma_idx == '0);  // R11

  AST_IDX_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (32'(dma_idx) + 32'd1 == 32'(ring_count))) |=> dma_idx == '0);  // R6

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             full,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W-1:0] dma_idx,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             adv,
  output logic             busy
);
  localparam int CNT_W = $clog2(BUF_BYTES) + 1;

  rx_state_e        state_q;
  logic [31:0]      desc_q;
  logic [31:0]      buf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  logic        storing;
  logic        accept;
  logic        start_ok;
  logic        start_drop;
  logic        data_fire;
  logic        done_fire;
  logic [31:0] byte_addr;

  assign storing    = cnt_q < CNT_W'(BUF_BYTES);
  assign byte_addr  = buf_q + 32'(cnt_q);
  assign start_ok   = (state_q == ST_IDLE) && s_valid && rx_en && !full;
  assign start_drop = (state_q == ST_IDLE) && s_valid && !(rx_en && !full);
  assign accept     = s_valid && s_ready;
  assign data_fire  = (state_q == ST_DATA) && mem_req && mem_gnt;
  assign done_fire  = (state_q == ST_DONE) && mem_gnt;
  assign adv        = done_fire;
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_be    = 4'hF;
    mem_wdata = '0;
    s_ready   = 1'b0;
    case (state_q)
      ST_DROP:  s_ready = 1'b1;
      ST_FETCH: mem_req = 1'b1;
      ST_DATA: begin
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{s_data}};
        mem_req   = s_valid && storing;
        s_ready   = storing ? mem_gnt : 1'b1;
      end
      ST_DONE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + 32'd4;
        mem_wdata = done_word(32'(cnt_q));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_FETCH;
            desc_q  <= desc_word_addr(ring_base, 32'(dma_idx), 2'd0);
          end else if (start_drop) begin
            state_q <= ST_DROP;
          end
        end
        ST_DROP:  if (accept && s_last) state_q <= ST_IDLE;
        ST_FETCH: if (mem_gnt) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            buf_q   <= mem_rdata;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (accept) begin
            if (storing) cnt_q <= cnt_q + 1'b1;
            else         ovf_q <= 1'b1;
            if (s_last) state_q <= (ovf_q || !storing) ? ST_IDLE : ST_DONE;
          end
        end
        ST_DONE:  if (mem_gnt) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_STALLS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH || state_q == ST_WAIT) |-> !s_ready);  // R3

  AST_START_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && $past(state_q == ST_IDLE)) |-> $past(rx_en && !full));  // R7

  AST_DROP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_req);  // R10

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |-> (cnt_q != '0 && cnt_q <= CNT_W'(BUF_BYTES)));  // R5

  AST_WR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |-> ((mem_addr - buf_q) < 32'(BUF_BYTES)));  // R9

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |-> $onehot0(mem_be) && mem_be != 4'h0);  // R4

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxdma_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  output logic        mem_req,
  input  logic        mem_gnt,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);

  logic [31:0]      ring_base;
  logic [IDX_W:0]   ring_count;
  logic [IDX_W-1:0] rel_idx;
  logic [IDX_W-1:0] dma_idx;
  logic             rx_en;
  logic             idx_clr;
  logic             full;
  logic             adv;
  logic             busy;

  rxdma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .dma_idx(dma_idx),
    .ring_base(ring_base), .ring_count(ring_count), .rel_idx(rel_idx),
    .rx_en(rx_en), .idx_clr(idx_clr)
  );

  rxdma_ring #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .adv(adv), .clr(idx_clr), .ring_count(ring_count), .rel_idx(rel_idx),
    .dma_idx(dma_idx), .full(full)
  );

  rxdma_engine #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .rx_en(rx_en), .full(full), .ring_base(ring_base), .dma_idx(dma_idx),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .adv(adv), .busy(busy)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_req && !s_ready);  // R1

endmodule

// File: tb/tb_rx_ring_dma.sv
`timescale 1ns/1ps
module tb_rx_ring_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic        mem_req;
  logic        mem_gnt;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  rx_ring_dma dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: descriptors below 0x100, buffer bytes mirrored by low address byte
  logic [31:0] desc [64];
  logic [7:0]  bytes [256];
  int          wr_count = 0;
  logic [3:0]  last_buf_page = '0;
  logic        stall_mode = 1'b0;
  logic        gnt_q = 1'b1;
  logic        poke_en = 1'b0;
  logic [5:0]  poke_a = '0;
  logic [31:0] poke_d = '0;
  logic        rv_q = 1'b0;
  logic [31:0] rd_q = '0;

  assign mem_gnt    = gnt_q;
  assign mem_rvalid = rv_q;
  assign mem_rdata  = rd_q;

  always @(posedge clk) begin
    gnt_q <= stall_mode ? ~gnt_q : 1'b1;
    rv_q  <= 1'b0;
    if (poke_en) desc[poke_a] <= poke_d;
    if (mem_req && mem_gnt) begin
      if (!mem_we) begin
        rv_q <= 1'b1;
        rd_q <= desc[mem_addr[7:2]];
      end else if (mem_addr < 32'h100) begin
        desc[mem_addr[7:2]] <= mem_wdata;
      end else begin
        bytes[mem_addr[7:0]] <= mem_wdata[8*mem_addr[1:0] +: 8];
        wr_count      <= wr_count + 1;
        last_buf_page <= mem_addr[15:12];
      end
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = 6'(a); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = last;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int k = 0; k < len; k++) send_byte(8'(seed + k), k == len - 1);
    repeat (10) @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam int          VEC_LEN   [NV] = '{1, 7, 60, 64, 3, 33};
  localparam logic [7:0]  VEC_SEED  [NV] = '{8'h11, 8'hA0, 8'h05, 8'h80, 8'hF0, 8'h3C};
  localparam logic        VEC_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  localparam logic [31:0] W2_INIT = 32'h4000_0000;

  function automatic logic [31:0] exp_done(input int len);
    return 32'h8000_0000 | 32'h4000_0000 | (32'(len) << 16);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int exp_idx;
    int wc0;

    repeat (4) @(negedge clk);
    // R1 reset state
    reg_read(3'd3, rd); check("R1 idx", rd, 0);
    reg_read(3'd4, rd); check("R1 cfg", rd, 0);
    check("R1 ready", 32'(s_ready), 0);
    check("R1 req", 32'(mem_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      poke(4*i, 32'h1000 * (i + 1));
      poke(4*i + 1, W2_INIT);
    end
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'd3);
    reg_write(3'd4, 32'h4);
    reg_read(3'd1, rd); check("R2 count", rd, 4);
    reg_read(3'd2, rd); check("R2 release", rd, 3);
    reg_read(3'd4, rd); check("R2 cfg", rd, 32'h4);

    exp_idx = 0;
    for (int v = 0; v < NV; v++) begin
      stall_mode = VEC_STALL[v];
      send_frame(VEC_LEN[v], VEC_SEED[v]);
      stall_mode = 1'b0;
      check("R5 done word", desc[4*exp_idx + 1], exp_done(VEC_LEN[v]));
      check("R4 first byte", 32'(bytes[0]), 32'(VEC_SEED[v]));
      check("R4 last byte", 32'(bytes[VEC_LEN[v] - 1]), 32'(8'(VEC_SEED[v] + VEC_LEN[v] - 1)));
      check("R3 buffer page", 32'(last_buf_page), 32'(exp_idx + 1));
      poke(4*exp_idx + 1, W2_INIT);
      reg_write(3'd2, 32'(exp_idx));
      exp_idx = (exp_idx + 1) % 4;
      reg_read(3'd3, rd); check("R6 idx advance", rd, 32'(exp_idx));
    end

    // R7 ring full: release equals DMA index (2)
    reg_write(3'd2, 32'd2);
    wc0 = wr_count;
    send_frame(4, 8'h55);
    check("R7 no writes", 32'(wr_count - wc0), 0);
    check("R7 desc untouched", desc[9], W2_INIT);
    reg_read(3'd3, rd); check("R7 idx held", rd, 2);

    // R8 release frees the ring
    reg_write(3'd2, 32'd1);
    send_frame(2, 8'h70);
    check("R8 stored", desc[9], exp_done(2));
    reg_read(3'd3, rd); check("R8 idx", rd, 3);

    // R10 disabled drop
    reg_write(3'd2, 32'd2);
    reg_write(3'd4, 32'h0);
    wc0 = wr_count;
    send_frame(5, 8'h20);
    check("R10 no writes", 32'(wr_count - wc0), 0);
    check("R10 desc untouched", desc[13], W2_INIT);
    reg_read(3'd3, rd); check("R10 idx held", rd, 3);
    reg_write(3'd4, 32'h4);

    // R12 busy during a frame
    send_byte(8'h01, 1'b0);
    reg_read(3'd4, rd); check("R12 busy set", rd, 32'hC);
    send_byte(8'h02, 1'b1);
    repeat (10) @(negedge clk);
    reg_read(3'd4, rd); check("R12 busy clear", rd, 32'h4);
    check("R12 frame done", desc[13], exp_done(2));
    reg_read(3'd3, rd); check("R6 wrap to 0", rd, 0);

    // R9 oversize and exact-size frames at index 0
    reg_write(3'd2, 32'd3);
    wc0 = wr_count;
    send_frame(2049, 8'h00);
    check("R9 truncated writes", 32'(wr_count - wc0), 2048);
    check("R9 no report", desc[1], W2_INIT);
    reg_read(3'd3, rd); check("R9 idx held", rd, 0);
    send_frame(2048, 8'h00);
    check("R9 exact length", desc[1], 32'hC800_0000);
    reg_read(3'd3, rd); check("R9 idx", rd, 1);

    // R11 index reset
    reg_write(3'd5, 32'h0000_0001);
    reg_read(3'd3, rd); check("R11 no clear", rd, 1);
    reg_write(3'd5, 32'h0001_0000);
    reg_read(3'd3, rd); check("R11 clear", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule